// File: doc/BRIEF.md
# Pulse-Ratio Serial Frame Receiver

This block listens to a single wire that idles high and decodes frames in which every bit is one high phase followed by one low phase. The bit value comes only from which phase is at least twice as long as the other, so the sender needs no clock shared with the receiver. All phase durations are measured in ticks of a one-microsecond strobe. A frame holds an address byte and a data byte. When the address matches and the reserved data bits are clear, the block loads a 5-bit dimming level. The level is turned into a feedback-voltage code in millivolts on a piecewise-linear curve.

Framing works as follows. A start condition is the wire high for at least `START_MIN` ticks and then falling. A short start gap follows. Each of the sixteen bits then begins at a rising edge. After the last bit comes a stop high phase. The end condition is the wire low for at least `END_MIN` ticks, and the frame is accepted at that moment. If the data byte asks for it, the block waits `ACK_DLY` ticks and then pulls the wire low for `ACK_LEN` ticks through an open-drain output. The receiver only works while `dig_en` is high. Choosing that mode is left to the surrounding logic.

Top module: `pulse_ratio_rx`

## Requirements
- R1: After reset, `level` is 31, `fb_mv` is 200, `wire_pull` is 0 and `frame_ok` is 0.
- R2: A bit whose low phase is at least twice its high phase decodes as 0. A bit whose high phase is at least twice its low phase decodes as 1. The sixteen bits arrive most significant first: the address byte, then the data byte. On a valid frame, `level` takes data bits 4..0 at the end condition.
- R3: A frame whose address byte is not 8'b01110010 leaves `level` unchanged.
- R4: A frame with data bit 6 or data bit 5 set leaves `level` unchanged.
- R5: A bit with a zero-length phase, or one where neither phase reaches twice the other, discards the frame and leaves `level` unchanged.
- R6: Any start-gap, bit or stop phase longer than `PHASE_MAX` ticks discards the frame. The receiver then waits for a fresh start condition, and a later valid frame is accepted.
- R7: When data bit 7 is 1 in an accepted frame, `wire_pull` rises `ACK_DLY` ticks after `frame_ok` and stays high for `ACK_LEN` ticks. While it is high, the wire is not decoded. When data bit 7 is 0, `wire_pull` stays low.
- R8: `fb_mv` follows `level` as follows. Code 0 gives 0. Codes 1..12 give 5 + 3*(code-1). Codes 13..23 give 38 + 6*(code-12). Codes 24..31 give 104 + 12*(code-23).
- R9: While `dig_en` is 0, wire activity changes nothing and `wire_pull` stays 0.
- R10: `frame_ok` is a single-cycle pulse. It is raised once for each accepted frame, in the cycle in which `level` shows the new value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| wire_in | input | 1 | Synchronized level of the serial wire |
| dig_en | input | 1 | Enables frame decoding |
| level | output | 5 | Dimming level register |
| fb_mv | output | 8 | Feedback voltage code in millivolts |
| frame_ok | output | 1 | Pulse when the level register updates |
| wire_pull | output | 1 | Open-drain pull-down enable for the acknowledge |

## Verification
The bench builds the block with `PHASE_MAX` = 40, `ACK_LEN` = 16, `ACK_DLY` = 2 and 2-tick start and end minimums. It drives one microsecond tick every four clocks. With these values, a phase that overruns its limit takes only tens of microseconds, and the full acknowledge window can be measured cycle by cycle. The short frames also make it cheap to sweep all 32 level codes through the millivolt curve. Every discard case is followed by a valid frame, which shows that the receiver recovers.

// File: rtl/prt_pkg.sv
`timescale 1ns/1ps
package prt_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_GAP, S_HI, S_LO, S_STOP, S_END, S_ACKD, S_ACKP
    } rx_state_e;

    localparam int unsigned LVL_W      = 5;
    localparam int unsigned MV_W       = 8;
    localparam int unsigned FRAME_BITS = 16;
    localparam logic [7:0]  DEV_ADDR   = 8'b0111_0010;
endpackage

// File: rtl/prt_bit_judge.sv
`timescale 1ns/1ps
module prt_bit_judge #(
    parameter int unsigned CW = 9
) (
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    output logic          bit_ok,
    output logic          bit_val
);
    logic [CW:0] hi_x2, lo_x2, hi_e, lo_e;
    logic        is_zero, is_one, nonzero;

    always_comb begin
        hi_e    = {1'b0, hi_len};
        lo_e    = {1'b0, lo_len};
        hi_x2   = {hi_len, 1'b0};
        lo_x2   = {lo_len, 1'b0};
        nonzero = (hi_len != '0) && (lo_len != '0);
        is_zero = lo_e >= hi_x2;
        is_one  = hi_e >= lo_x2;
        bit_ok  = nonzero && (is_zero || is_one);
        bit_val = is_one;
    end
endmodule

// File: rtl/prt_level_map.sv
`timescale 1ns/1ps
module prt_level_map
    import prt_pkg::*;
(
    input  logic [LVL_W-1:0] code,
    output logic [MV_W-1:0]  mv
);
    int c_i, mv_i;

    always_comb begin
        c_i = int'(code);
        if (c_i == 0)       mv_i = 0;
        else if (c_i <= 12) mv_i = 3 * c_i + 2;
        else if (c_i <= 23) mv_i = 6 * c_i - 34;
        else                mv_i = 12 * c_i - 172;
        mv = MV_W'(mv_i);
    end
endmodule

// File: rtl/pulse_ratio_rx.sv
`timescale 1ns/1ps
module pulse_ratio_rx
    import prt_pkg::*;
#(
    parameter int unsigned START_MIN = 2,
    parameter int unsigned END_MIN   = 2,
    parameter int unsigned PHASE_MAX = 360,
    parameter int unsigned ACK_DLY   = 2,
    parameter int unsigned ACK_LEN   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             wire_in,
    input  logic             dig_en,
    output logic [LVL_W-1:0] level,
    output logic [MV_W-1:0]  fb_mv,
    output logic             frame_ok,
    output logic             wire_pull
);
    localparam int unsigned M1      = (PHASE_MAX > ACK_LEN) ? PHASE_MAX : ACK_LEN;
    localparam int unsigned M2      = (START_MIN > END_MIN) ? START_MIN : END_MIN;
    localparam int unsigned M3      = (M2 > ACK_DLY) ? M2 : ACK_DLY;
    localparam int unsigned CNT_MAX = (M1 > M3) ? M1 : M3;
    localparam int unsigned CW      = $clog2(CNT_MAX + 2);
    localparam int unsigned NB_W    = $clog2(FRAME_BITS);

    typedef struct packed {
        rx_state_e             st;
        logic [CW-1:0]         cnt;
        logic [CW-1:0]         hi_len;
        logic [FRAME_BITS-1:0] sh;
        logic [NB_W-1:0]       nb;
        logic                  wire_q;
        logic [LVL_W-1:0]      lvl;
        logic                  ok;
    } rx_t;

    rx_t r_d, r_q;

    logic rise, fall, over, bit_ok, bit_val;
    logic [CW-1:0] cnt_inc;
    logic [FRAME_BITS-1:0] sh_next;

    prt_bit_judge #(.CW(CW)) u_judge (
        .hi_len (r_q.hi_len),
        .lo_len (r_q.cnt),
        .bit_ok (bit_ok),
        .bit_val(bit_val)
    );

    prt_level_map u_map (
        .code(r_q.lvl),
        .mv  (fb_mv)
    );

    always_comb begin
        r_d        = r_q;
        r_d.ok     = 1'b0;
        r_d.wire_q = wire_in;
        rise       = wire_in & ~r_q.wire_q;
        fall       = ~wire_in & r_q.wire_q;
        cnt_inc    = r_q.cnt + CW'(1);
        over       = us_tick && (r_q.cnt >= CW'(PHASE_MAX));
        sh_next    = {r_q.sh[FRAME_BITS-2:0], bit_val};

        unique case (r_q.st)
            S_IDLE: begin
                if (fall && r_q.cnt >= CW'(START_MIN)) begin
                    r_d.st  = S_GAP;
                    r_d.cnt = '0;
                    r_d.nb  = '0;
                end else if (!wire_in) begin
                    r_d.cnt = '0;
                end else if (us_tick && r_q.cnt < CW'(START_MIN)) begin
                    r_d.cnt = cnt_inc;
                end
            end
            S_GAP, S_HI, S_STOP: begin
                if ((r_q.st == S_GAP) ? rise : fall) begin
                    r_d.st     = (r_q.st == S_GAP) ? S_HI :
                                 (r_q.st == S_HI)  ? S_LO : S_END;
                    r_d.hi_len = r_q.cnt;
                    r_d.cnt    = '0;
                end else if (over) begin
                    r_d.st  = S_IDLE;
                    r_d.cnt = '0;
                end else if (us_tick) begin
                    r_d.cnt = cnt_inc;
                end
            end
            S_LO: begin
                if (rise) begin
                    r_d.cnt = '0;
                    if (!bit_ok) begin
                        r_d.st = S_IDLE;
                    end else begin
                        r_d.sh = sh_next;
                        if (r_q.nb == NB_W'(FRAME_BITS - 1)) begin
                            r_d.st = S_STOP;
                        end else begin
                            r_d.nb = r_q.nb + NB_W'(1);
                            r_d.st = S_HI;
                        end
                    end
                end else if (over) begin
                    r_d.st  = S_IDLE;
                    r_d.cnt = '0;
                end else if (us_tick) begin
                    r_d.cnt = cnt_inc;
                end
            end
            S_END: begin
                if (rise) begin
                    r_d.st  = S_IDLE;
                    r_d.cnt = '0;
                end else if (us_tick) begin
                    if (cnt_inc >= CW'(END_MIN)) begin
                        r_d.cnt = '0;
                        r_d.st  = S_IDLE;
                        if (r_q.sh[15:8] == DEV_ADDR && r_q.sh[6:5] == 2'b00) begin
                            r_d.lvl = r_q.sh[LVL_W-1:0];
                            r_d.ok  = 1'b1;
                            if (r_q.sh[7]) r_d.st = S_ACKD;
                        end
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
            end
            S_ACKD: begin
                if (us_tick) begin
                    if (cnt_inc >= CW'(ACK_DLY)) begin
                        r_d.st  = S_ACKP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
            end
            S_ACKP: begin
                if (us_tick) begin
                    if (cnt_inc >= CW'(ACK_LEN)) begin
                        r_d.st  = S_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
            end
            default: begin
                r_d.st  = S_IDLE;
                r_d.cnt = '0;
            end
        endcase

        if (!dig_en) begin
            r_d.st  = S_IDLE;
            r_d.cnt = '0;
            r_d.ok  = 1'b0;
            r_d.lvl = r_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.wire_q <= 1'b1;
            r_q.lvl    <= LVL_W'(31);
        end else begin
            r_q <= r_d;
        end
    end

    assign level     = r_q.lvl;
    assign frame_ok  = r_q.ok;
    assign wire_pull = (r_q.st == S_ACKP);

    a_r10_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);
    a_r2_level_only_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |-> $stable(level));
    a_r7_pull_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wire_pull) |-> $past(r_q.st == S_ACKD));
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_en |=> (!wire_pull && !frame_ok));
    a_r8_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(31)) |-> (fb_mv == MV_W'(200)));
    a_r8_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (fb_mv == '0));
    a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {S_GAP, S_HI, S_LO, S_STOP}) |-> (r_q.cnt <= CW'(PHASE_MAX)));
endmodule

// File: tb/pulse_ratio_rx_test.sv
`timescale 1ns/1ps
module pulse_ratio_rx_test;
    localparam int DIV   = 4;
    localparam int PMAX  = 40;
    localparam int ALEN  = 16;
    localparam int ADLY  = 2;

    logic clk = 1'b0;
    logic rst_n, us_tick, dig_en, drv;
    logic wire_in;
    logic [4:0] level;
    logic [7:0] fb_mv;
    logic frame_ok, wire_pull;

    int tests = 0, fails = 0;
    int cyc = 0, ok_cnt = 0, ok_cyc = 0, ack_cyc = 0, pull_start = 0;

    always #2.5 clk = ~clk;
    assign wire_in = drv & ~wire_pull;

    pulse_ratio_rx #(.START_MIN(2), .END_MIN(2), .PHASE_MAX(PMAX),
                     .ACK_DLY(ADLY), .ACK_LEN(ALEN)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wire_in(wire_in),
        .dig_en(dig_en), .level(level), .fb_mv(fb_mv),
        .frame_ok(frame_ok), .wire_pull(wire_pull));

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic [4:0] lvl;
        logic       ok;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h72, 8'h10, 5'd16, 1'b1, 1'b0},
        '{8'h72, 8'h80, 5'd0,  1'b1, 1'b1},
        '{8'h72, 8'h8C, 5'd12, 1'b1, 1'b1},
        '{8'h73, 8'h05, 5'd12, 1'b0, 1'b0},
        '{8'h72, 8'h25, 5'd12, 1'b0, 1'b0},
        '{8'h72, 8'h45, 5'd12, 1'b0, 1'b0},
        '{8'h72, 8'h17, 5'd23, 1'b1, 1'b0},
        '{8'h72, 8'h01, 5'd1,  1'b1, 1'b0},
        '{8'hF2, 8'h03, 5'd1,  1'b0, 1'b0},
        '{8'h72, 8'h9F, 5'd31, 1'b1, 1'b1}
    };

    initial begin
        us_tick = 1'b0;
        forever begin
            repeat (DIV - 1) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (frame_ok) begin ok_cnt++; ok_cyc = cyc; end
            if (wire_pull) begin
                if (ack_cyc == 0) pull_start = cyc;
                ack_cyc++;
            end
        end
    end

    function automatic int exp_mv(input int c);
        if (c == 0) return 0;
        if (c <= 12) return 5 + 3 * (c - 1);
        if (c <= 23) return 38 + 6 * (c - 12);
        return 104 + 12 * (c - 23);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic hold(input logic v, input int us);
        drv = v;
        repeat (us * DIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] d,
                        input int bad_idx, input int bh, input int bl);
        logic [15:0] w;
        w = {a, d};
        ok_cnt = 0; ack_cyc = 0; pull_start = 0; ok_cyc = 0;
        hold(1'b1, 5);
        hold(1'b0, 3);
        for (int i = 0; i < 16; i++) begin
            if (i == bad_idx) begin hold(1'b1, bh); hold(1'b0, bl); end
            else if (w[15-i]) begin hold(1'b1, 9); hold(1'b0, 3); end
            else begin hold(1'b1, 3); hold(1'b0, 9); end
        end
        hold(1'b1, 3);
        hold(1'b0, 4);
        hold(1'b1, 60);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dig_en = 1'b1; drv = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 level", int'(level), 31);
        check("R1 fb_mv", int'(fb_mv), 200);
        check("R1 pull", int'(wire_pull), 0);
        check("R1 ok", int'(frame_ok), 0);

        // R2 R3 R4 R7 R10 table walk
        foreach (VECS[k]) begin
            send(VECS[k].a, VECS[k].d, -1, 0, 0);
            check("R2 R3 R4 level", int'(level), int'(VECS[k].lvl));
            check("R10 ok pulses", ok_cnt, int'(VECS[k].ok));
            if (VECS[k].ack) begin
                check_rng("R7 ack length", ack_cyc, (ALEN - 1) * DIV + 1, ALEN * DIV);
                check_rng("R7 ack delay", pull_start - ok_cyc, (ADLY - 1) * DIV + 1, ADLY * DIV);
            end else begin
                check("R7 no ack", ack_cyc, 0);
            end
        end

        // R5 ambiguous ratio, then zero-free but equal phases
        send(8'h72, 8'h05, 9, 6, 6);
        check("R5 ambiguous level", int'(level), 31);
        check("R5 ambiguous ok", ok_cnt, 0);

        // R6 overlong high phase, then recovery
        send(8'h72, 8'h05, 4, 50, 3);
        check("R6 overlong level", int'(level), 31);
        check("R6 overlong ok", ok_cnt, 0);
        send(8'h72, 8'h06, -1, 0, 0);
        check("R6 recovery level", int'(level), 6);

        // R9 disabled
        dig_en = 1'b0;
        send(8'h72, 8'h85, -1, 0, 0);
        check("R9 disabled level", int'(level), 6);
        check("R9 disabled ok", ok_cnt, 0);
        check("R9 disabled pull", ack_cyc, 0);
        dig_en = 1'b1;

        // R8 sweep of all codes
        for (int c = 0; c < 32; c++) begin
            send(8'h72, 8'(c), -1, 0, 0);
            check("R8 level", int'(level), c);
            check("R8 fb_mv", int'(fb_mv), exp_mv(c));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule